// File: doc/BRIEF.md
# Interleaved Chunk-and-Spare Page Transfer Sequencer

This block orders the byte traffic for a flash page kept in an interleaved layout, where every 512-byte data chunk is immediately followed by its own 16-byte spare segment. It sits between a host-side byte stream and a flash-side byte stream. It does not compute ECC and does not correct errors. Its job is to decide which bytes cross the flash interface and in what order, when a column seek is needed, and when the single program command is issued.

On a write, the block pulses a restart strobe to an external ECC engine before each chunk. It then passes 512 host bytes through to the flash. After that it emits a 16-byte spare segment built from six pad bytes and the ten packed ECC bytes presented on `ecc_in`. Once the last segment is out, it pulses the program command and waits for the device to report ready.

On a read, the caller asks for some number of data bytes and some number of spare bytes. The block walks the page one chunk slot at a time. It keeps a wanted column and a current column, and requests a random-column seek only when the two differ. All byte streams use valid/ready handshakes, and a stalled transfer simply waits. A valid, once raised, stays up with its data unchanged until ready is seen.

Top module: `infix_xfer_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `fl_tx_valid`, `rd_valid`, `seek_req`, `prog_cmd` and `ecc_restart` are all low.
- R2: A write moves floor(`data_len`/512) chunks. Each chunk is preceded by exactly one `ecc_restart` pulse, issued before any byte of that chunk is sent. The chunk then carries 512 host bytes to `fl_tx_data` in arrival order, followed by 16 spare bytes.
- R3: In each spare segment, bytes 0 to 5 are 0xFF. Byte 6+j, for j from 0 to 9, equals `ecc_in[8*j+7:8*j]`.
- R4: A write ends with exactly one single-cycle `prog_cmd` pulse, issued after the last spare byte and followed by no further bytes. When `dev_ready` is then seen high, `done` pulses for one cycle.
- R5: On a read, each data slot passes min(512, remaining data) bytes to the host with `rd_spare` low. The wanted column then advances by 512, whether or not data was read in that slot.
- R6: On a read, each spare slot passes min(16, remaining spare) bytes with `rd_spare` high. The wanted column then advances by 16.
- R7: Before a slot transfers bytes, a seek is requested with `seek_col` equal to the wanted column, but only if the wanted column differs from the current column. A successful seek sets the current column to the wanted one, and each byte read advances the current column by one.
- R8: A read continues while any data or spare bytes remain. When both counts reach zero, `done` pulses; a read that requests zero of both finishes with no transfers.
- R9: A seek answered with `seek_err` high, or left unanswered for TMO_CYC cycles, ends the operation with a one-cycle `err` pulse, no `done`, and `busy` low.
- R10: If `dev_ready` stays low for TMO_CYC cycles after the program command, the write ends with `err` and no `done`.
- R11: When a flash-side byte is offered and not accepted, `fl_tx_valid` stays high and `fl_tx_data` stays unchanged in the next cycle. Stalls on any ready input delay the transfer but never drop or repeat a byte.
- R12: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| op_write | input | 1 | 1 = write page, 0 = read |
| data_len | input | COL_W | Data bytes requested |
| spare_len | input | SPR_W | Spare bytes requested (read) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle failure pulse |
| wr_valid | input | 1 | Host write byte valid |
| wr_ready | output | 1 | Host write byte accepted |
| wr_data | input | 8 | Host write byte |
| ecc_in | input | 8*ECC_BYTES | Packed ECC bytes for the current chunk |
| ecc_restart | output | 1 | Restart the ECC engine for a new chunk |
| fl_tx_valid | output | 1 | Flash-side byte valid |
| fl_tx_ready | input | 1 | Flash-side byte accepted |
| fl_tx_data | output | 8 | Byte to flash |
| prog_cmd | output | 1 | Program command pulse |
| dev_ready | input | 1 | Device ready after program |
| seek_req | output | 1 | Column seek request |
| seek_col | output | COL_W | Column to seek to |
| seek_ack | input | 1 | Seek finished (one-cycle pulse) |
| seek_err | input | 1 | Seek failed, valid with `seek_ack` |
| fl_rx_valid | input | 1 | Byte from flash valid |
| fl_rx_ready | output | 1 | Byte from flash accepted |
| fl_rx_data | input | 8 | Byte from flash |
| rd_valid | output | 1 | Host read byte valid |
| rd_ready | input | 1 | Host read byte accepted |
| rd_data | output | 8 | Host read byte |
| rd_spare | output | 1 | Current read byte belongs to a spare segment |

## Verification
The hold property on the flash transmit stream relies on the host write stream keeping `wr_valid` high and `wr_data` steady until accepted. It also relies on `ecc_in` staying constant for the whole spare segment. The seek-hold property relies on `seek_ack` being a single-cycle pulse that arrives only while `seek_req` is high. The stimulus stays within these limits in four ways: it keeps `wr_valid` high and changes `wr_data` only after acceptance, it fixes `ecc_in` before each operation, it acknowledges a seek two cycles after seeing it, and it applies back-pressure only through the ready inputs.

// File: rtl/infix_pkg.sv
package infix_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_W_ECC,
    ST_W_DATA,
    ST_W_SPARE,
    ST_W_PROG,
    ST_W_WAIT,
    ST_R_CHK_D,
    ST_R_DATA,
    ST_R_CHK_S,
    ST_R_SPARE,
    ST_SEEK
  } seq_st_e;
endpackage

// File: rtl/infix_col_track.sv
// Wanted/current column pair for the read walk (R5, R6, R7).
module infix_col_track #(
  parameter int COL_W       = 13,
  parameter int CHUNK_BYTES = 512,
  parameter int SPARE_BYTES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv_chunk,
  input  logic             adv_spare,
  input  logic             step,
  input  logic             sync,
  output logic [COL_W-1:0] want,
  output logic [COL_W-1:0] at,
  output logic             mismatch
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want <= '0;
      at   <= '0;
    end else begin
      if (clr)            want <= '0;
      else if (adv_chunk) want <= want + COL_W'(CHUNK_BYTES);
      else if (adv_spare) want <= want + COL_W'(SPARE_BYTES);

      if (clr)       at <= '0;
      else if (sync) at <= want;
      else if (step) at <= at + COL_W'(1);
    end
  end

  assign mismatch = (want != at);
endmodule

// File: rtl/infix_spare_mux.sv
// Builds one spare segment: pad bytes, then packed ECC bytes (R3).
module infix_spare_mux #(
  parameter int         SPARE_BYTES = 16,
  parameter int         PAD_BYTES   = 6,
  parameter int         ECC_BYTES   = 10,
  parameter logic [7:0] PAD_VAL     = 8'hFF,
  localparam int        SIDX_W      = $clog2(SPARE_BYTES)
) (
  input  logic [8*ECC_BYTES-1:0] ecc_in,
  input  logic [SIDX_W-1:0]      idx,
  output logic [7:0]             byte_o
);
  logic [7:0] seg [SPARE_BYTES];

  for (genvar k = 0; k < SPARE_BYTES; k++) begin : g_seg
    if (k >= PAD_BYTES && k < PAD_BYTES + ECC_BYTES) begin : g_ecc
      assign seg[k] = ecc_in[8*(k-PAD_BYTES) +: 8];
    end else begin : g_pad
      assign seg[k] = PAD_VAL;
    end
  end

  assign byte_o = seg[idx];
endmodule

// File: rtl/infix_timer.sv
// Wait watchdog for seek and post-program ready (R9, R10).
module infix_timer #(
  parameter int TMO_CYC = 64,
  localparam int TMO_W  = $clog2(TMO_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!expired) cnt <= cnt + TMO_W'(1);
  end

  assign expired = (cnt >= TMO_W'(TMO_CYC));
endmodule

// File: rtl/infix_xfer_seq.sv
module infix_xfer_seq
  import infix_pkg::*;
#(
  parameter int         COL_W       = 13,
  parameter int         SPR_W       = 8,
  parameter int         CHUNK_BYTES = 512,
  parameter int         SPARE_BYTES = 16,
  parameter int         PAD_BYTES   = 6,
  parameter int         ECC_BYTES   = 10,
  parameter int         TMO_CYC     = 64,
  parameter logic [7:0] PAD_VAL     = 8'hFF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   op_write,
  input  logic [COL_W-1:0]       data_len,
  input  logic [SPR_W-1:0]       spare_len,
  output logic                   busy,
  output logic                   done,
  output logic                   err,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [7:0]             wr_data,
  input  logic [8*ECC_BYTES-1:0] ecc_in,
  output logic                   ecc_restart,
  output logic                   fl_tx_valid,
  input  logic                   fl_tx_ready,
  output logic [7:0]             fl_tx_data,
  output logic                   prog_cmd,
  input  logic                   dev_ready,
  output logic                   seek_req,
  output logic [COL_W-1:0]       seek_col,
  input  logic                   seek_ack,
  input  logic                   seek_err,
  input  logic                   fl_rx_valid,
  output logic                   fl_rx_ready,
  input  logic [7:0]             fl_rx_data,
  output logic                   rd_valid,
  input  logic                   rd_ready,
  output logic [7:0]             rd_data,
  output logic                   rd_spare
);
  localparam int CHUNK_LG = $clog2(CHUNK_BYTES);
  localparam int SEG_W    = CHUNK_LG + 1;
  localparam int SIDX_W   = $clog2(SPARE_BYTES);

  seq_st_e           state;
  logic [COL_W-1:0]  data_rem;
  logic [SPR_W-1:0]  spare_rem;
  logic [SEG_W-1:0]  seg_cnt;
  logic [SIDX_W-1:0] sidx;
  logic              seek_ret;
  logic              done_q, err_q;

  logic [COL_W-1:0]  want, at;
  logic              mismatch, expired;
  logic              trk_clr, trk_step, trk_adv_c, trk_adv_s, trk_sync;
  logic [7:0]        spare_byte;
  logic              tx_fire, rx_fire, in_rd, seg_last;
  logic [SEG_W-1:0]  d_take, s_take;

  infix_col_track #(.COL_W(COL_W), .CHUNK_BYTES(CHUNK_BYTES), .SPARE_BYTES(SPARE_BYTES)) u_trk (
    .clk(clk), .rst_n(rst_n), .clr(trk_clr), .adv_chunk(trk_adv_c), .adv_spare(trk_adv_s),
    .step(trk_step), .sync(trk_sync), .want(want), .at(at), .mismatch(mismatch)
  );

  infix_spare_mux #(.SPARE_BYTES(SPARE_BYTES), .PAD_BYTES(PAD_BYTES), .ECC_BYTES(ECC_BYTES),
                    .PAD_VAL(PAD_VAL)) u_spr (
    .ecc_in(ecc_in), .idx(sidx), .byte_o(spare_byte)
  );

  infix_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(state == ST_SEEK || state == ST_W_WAIT), .expired(expired)
  );

  // Stream steering (R2, R5, R6, R11)
  always_comb begin
    in_rd       = (state == ST_R_DATA) || (state == ST_R_SPARE);
    wr_ready    = (state == ST_W_DATA) && fl_tx_ready;
    fl_tx_valid = ((state == ST_W_DATA) && wr_valid) || (state == ST_W_SPARE);
    fl_tx_data  = (state == ST_W_SPARE) ? spare_byte : wr_data;
    rd_valid    = in_rd && fl_rx_valid;
    fl_rx_ready = in_rd && rd_ready;
    rd_data     = fl_rx_data;
    rd_spare    = (state == ST_R_SPARE);
    tx_fire     = fl_tx_valid && fl_tx_ready;
    rx_fire     = rd_valid && rd_ready;
    seg_last    = (seg_cnt == SEG_W'(1));
    seek_req    = (state == ST_SEEK);
    seek_col    = want;
    ecc_restart = (state == ST_W_ECC);
    prog_cmd    = (state == ST_W_PROG);
    busy        = (state != ST_IDLE);
    done        = done_q;
    err         = err_q;
    d_take      = (data_rem > COL_W'(CHUNK_BYTES)) ? SEG_W'(CHUNK_BYTES) : data_rem[SEG_W-1:0];
    s_take      = (spare_rem > SPR_W'(SPARE_BYTES)) ? SEG_W'(SPARE_BYTES) : SEG_W'(spare_rem);
  end

  // Column tracker strobes (R5, R6, R7)
  always_comb begin
    trk_clr   = (state == ST_IDLE) && start;
    trk_step  = rx_fire;
    trk_sync  = (state == ST_SEEK) && seek_ack && !seek_err;
    trk_adv_c = ((state == ST_R_CHK_D) && (data_rem == '0) && (spare_rem != '0)) ||
                ((state == ST_R_DATA) && rx_fire && seg_last);
    trk_adv_s = ((state == ST_R_CHK_S) && (spare_rem == '0)) ||
                ((state == ST_R_SPARE) && rx_fire && seg_last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      data_rem  <= '0;
      spare_rem <= '0;
      seg_cnt   <= '0;
      sidx      <= '0;
      seek_ret  <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin  // R12: only sampled here
          if (op_write) begin
            data_rem <= {data_len[COL_W-1:CHUNK_LG], {CHUNK_LG{1'b0}}};
            if (data_len[COL_W-1:CHUNK_LG] == '0) done_q <= 1'b1;
            else state <= ST_W_ECC;
          end else begin
            data_rem  <= data_len;
            spare_rem <= spare_len;
            state     <= ST_R_CHK_D;
          end
        end
        ST_W_ECC: begin
          seg_cnt <= SEG_W'(CHUNK_BYTES);
          state   <= ST_W_DATA;
        end
        ST_W_DATA: if (tx_fire) begin
          data_rem <= data_rem - COL_W'(1);
          seg_cnt  <= seg_cnt - SEG_W'(1);
          if (seg_last) begin
            sidx  <= '0;
            state <= ST_W_SPARE;
          end
        end
        ST_W_SPARE: if (tx_fire) begin
          sidx <= sidx + SIDX_W'(1);
          if (sidx == SIDX_W'(SPARE_BYTES - 1))
            state <= (data_rem == '0) ? ST_W_PROG : ST_W_ECC;
        end
        ST_W_PROG: state <= ST_W_WAIT;
        ST_W_WAIT: begin
          if (dev_ready) begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else if (expired) begin  // R10
            err_q <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_R_CHK_D: begin
          if (data_rem == '0 && spare_rem == '0) begin  // R8
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else if (data_rem == '0) begin
            state <= ST_R_CHK_S;
          end else if (mismatch) begin
            seek_ret <= 1'b0;
            state    <= ST_SEEK;
          end else begin
            seg_cnt <= d_take;
            state   <= ST_R_DATA;
          end
        end
        ST_R_DATA: if (rx_fire) begin
          data_rem <= data_rem - COL_W'(1);
          seg_cnt  <= seg_cnt - SEG_W'(1);
          if (seg_last) state <= ST_R_CHK_S;
        end
        ST_R_CHK_S: begin
          if (spare_rem == '0) begin
            state <= ST_R_CHK_D;
          end else if (mismatch) begin
            seek_ret <= 1'b1;
            state    <= ST_SEEK;
          end else begin
            seg_cnt <= s_take;
            state   <= ST_R_SPARE;
          end
        end
        ST_R_SPARE: if (rx_fire) begin
          spare_rem <= spare_rem - SPR_W'(1);
          seg_cnt   <= seg_cnt - SEG_W'(1);
          if (seg_last) state <= ST_R_CHK_D;
        end
        ST_SEEK: begin
          if (seek_ack) begin
            if (seek_err) begin  // R9
              err_q <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state <= seek_ret ? ST_R_CHK_S : ST_R_CHK_D;
            end
          end else if (expired) begin  // R9
            err_q <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/infix_xfer_chk.sv
module infix_xfer_chk #(
  parameter int COL_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic             fl_tx_valid,
  input logic             fl_tx_ready,
  input logic [7:0]       fl_tx_data,
  input logic             seek_req,
  input logic             seek_ack,
  input logic [COL_W-1:0] seek_col,
  input logic             prog_cmd,
  input logic             ecc_restart,
  input logic             rd_valid
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fl_tx_valid && !rd_valid && !seek_req && !prog_cmd && !ecc_restart);

  p_restart_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_restart |=> !ecc_restart && busy);

  p_prog_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    prog_cmd |=> !prog_cmd && !fl_tx_valid);

  p_seek_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seek_req && !seek_ack |=> (seek_req && $stable(seek_col)) || err);

  p_end_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !busy && !(done && err));

  p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fl_tx_valid && !fl_tx_ready |=> fl_tx_valid && $stable(fl_tx_data));
endmodule

bind infix_xfer_seq infix_xfer_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .fl_tx_valid(fl_tx_valid), .fl_tx_ready(fl_tx_ready), .fl_tx_data(fl_tx_data),
  .seek_req(seek_req), .seek_ack(seek_ack), .seek_col(seek_col),
  .prog_cmd(prog_cmd), .ecc_restart(ecc_restart), .rd_valid(rd_valid)
);

// File: tb/sim_infix_xfer_seq.sv
`timescale 1ns/1ps
module sim_infix_xfer_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start = 0, op_write = 0;
  logic [12:0] data_len = '0;
  logic [7:0]  spare_len = '0;
  logic        busy, done, err;
  logic        wr_valid = 1, wr_ready;
  logic [7:0]  wr_data = '0;
  logic [79:0] ecc_in = '0;
  logic        ecc_restart, fl_tx_valid, fl_tx_ready = 1;
  logic [7:0]  fl_tx_data;
  logic        prog_cmd, dev_ready = 1;
  logic        seek_req, seek_ack = 0, seek_err = 0;
  logic [12:0] seek_col;
  logic        fl_rx_valid = 1, fl_rx_ready;
  logic [7:0]  fl_rx_data = '0;
  logic        rd_valid, rd_ready = 1, rd_spare;
  logic [7:0]  rd_data;

  infix_xfer_seq u0 (.*);

  int n_tests = 0, n_fail = 0;
  int cyc_n = 0, bp = 0, seek_mode = 0, seek_wait = 0;
  int tx_n, rd_n, sk_n, prog_n, prog_at, rs_n, done_n, err_n, wr_cnt, flc;
  logic [7:0] tx_log [0:8191];
  logic [7:0] rd_log [0:8191];
  logic       rd_sp  [0:8191];
  int         rs_at  [0:15];
  int         sk_log [0:63];
  int         ec [0:8191];
  logic       esp [0:8191];
  int         es [0:63];
  int         ne, ns;

  function automatic logic [7:0] pat_w(int n);
    return 8'(n * 37 + 11);
  endfunction
  function automatic logic [7:0] pat_c(int c);
    return 8'(c) ^ 8'(c >> 5) ^ 8'h3C;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Responder and monitor: inputs set just after the falling edge, handshakes logged 1 ns later.
  initial forever begin
    @(negedge clk);
    cyc_n++;
    fl_tx_ready = (bp != 0) ? (cyc_n % 3 != 0) : 1'b1;
    rd_ready    = (bp != 0) ? (cyc_n % 4 != 1) : 1'b1;
    wr_data     = pat_w(wr_cnt);
    fl_rx_data  = pat_c(flc);
    seek_ack = 0; seek_err = 0;
    if (seek_req && seek_mode != 2) begin
      seek_wait++;
      if (seek_wait == 2) begin
        seek_ack = 1;
        seek_err = (seek_mode == 1);
        if (seek_mode == 0) flc = int'(seek_col);
        sk_log[sk_n] = int'(seek_col);
        sk_n++;
        seek_wait = 0;
      end
    end else seek_wait = 0;
    #1;
    if (fl_tx_valid && fl_tx_ready) begin tx_log[tx_n] = fl_tx_data; tx_n++; end
    if (wr_valid && wr_ready) wr_cnt++;
    if (rd_valid && rd_ready) begin rd_log[rd_n] = rd_data; rd_sp[rd_n] = rd_spare; rd_n++; flc++; end
    if (prog_cmd) begin prog_n++; prog_at = tx_n; end
    if (ecc_restart) begin if (rs_n < 16) rs_at[rs_n] = tx_n; rs_n++; end
    if (done) done_n++;
    if (err) err_n++;
  end

  task automatic clear_logs();
    tx_n = 0; rd_n = 0; sk_n = 0; prog_n = 0; prog_at = -1; rs_n = 0;
    done_n = 0; err_n = 0; wr_cnt = 0; flc = 0;
  endtask

  task automatic kick(input bit w, input int dl, input int sl);
    @(negedge clk);
    start = 1; op_write = w; data_len = 13'(dl); spare_len = 8'(sl);
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 30000 && done_n == 0 && err_n == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check(!busy && !done && !err, "R1 status idle", {busy, done, err}, 0);
    check(!fl_tx_valid && !rd_valid, "R1 streams idle", {fl_tx_valid, rd_valid}, 0);
    check(!seek_req && !prog_cmd && !ecc_restart, "R1 strobes idle",
          {seek_req, prog_cmd, ecc_restart}, 0);
  endtask

  task automatic t_write(input int nch, input int bpm);
    int bad_d, bad_s, bad_r;
    bp = bpm;
    ecc_in = {8'h9A, 8'h89, 8'h78, 8'h67, 8'h56, 8'h45, 8'h34, 8'h23, 8'h12, 8'h01} ^ {10{8'(nch)}};
    clear_logs();
    kick(1, nch * 512, 0);
    wait_end();
    bad_d = 0; bad_s = 0; bad_r = 0;
    for (int i = 0; i < tx_n; i++) begin
      int c = i / 528, off = i % 528;
      if (off < 512) begin
        if (tx_log[i] != pat_w(c * 512 + off)) bad_d++;
      end else if (off - 512 < 6) begin
        if (tx_log[i] != 8'hFF) bad_s++;
      end else if (tx_log[i] != ecc_in[8*(off-518) +: 8]) bad_s++;
    end
    for (int k = 0; k < nch && k < 16; k++) if (rs_at[k] != k * 528) bad_r++;
    check(tx_n == nch * 528, "R2 byte count", tx_n, nch * 528);
    check(bad_d == 0, "R2/R11 data order", bad_d, 0);
    check(rs_n == nch && bad_r == 0, "R2 restart per chunk", rs_n, nch);
    check(bad_s == 0, "R3 spare pad/ecc", bad_s, 0);
    check(prog_n == 1 && prog_at == nch * 528, "R4 single program at end", prog_at, nch * 528);
    check(done_n == 1 && err_n == 0, "R4 done", done_n, 1);
    bp = 0;
  endtask

  task automatic model_read(input int dl, input int sl);
    int want = 0, at = 0;
    ne = 0; ns = 0;
    while (dl > 0 || sl > 0) begin
      if (dl > 0) begin
        int n = (dl > 512) ? 512 : dl;
        if (want != at) begin es[ns] = want; ns++; at = want; end
        for (int i = 0; i < n; i++) begin ec[ne] = at + i; esp[ne] = 0; ne++; end
        at += n; dl -= n;
      end
      want += 512;
      if (sl > 0) begin
        int n = (sl > 16) ? 16 : sl;
        if (want != at) begin es[ns] = want; ns++; at = want; end
        for (int i = 0; i < n; i++) begin ec[ne] = at + i; esp[ne] = 1; ne++; end
        at += n; sl -= n;
      end
      want += 16;
    end
  endtask

  task automatic t_read(input int dl, input int sl, input int bpm, input string tag);
    int bad_b, bad_k;
    bp = bpm;
    model_read(dl, sl);
    clear_logs();
    kick(0, dl, sl);
    wait_end();
    bad_b = 0; bad_k = 0;
    for (int i = 0; i < rd_n && i < ne; i++)
      if (rd_log[i] != pat_c(ec[i]) || rd_sp[i] != esp[i]) bad_b++;
    for (int i = 0; i < sk_n && i < ns; i++) if (sk_log[i] != es[i]) bad_k++;
    check(rd_n == ne, {tag, " R5/R6 read count"}, rd_n, ne);
    check(bad_b == 0, {tag, " R5/R6 bytes and spare flag"}, bad_b, 0);
    check(sk_n == ns && bad_k == 0, {tag, " R7 seeks"}, sk_n, ns);
    check(done_n == 1 && err_n == 0 && !busy, {tag, " R8 completion"}, done_n, 1);
    bp = 0;
  endtask

  task automatic t_seek_fault(input int mode, input string tag);
    seek_mode = mode;
    clear_logs();
    kick(0, 0, 16);
    wait_end();
    check(err_n == 1 && done_n == 0, {tag, " R9 error pulse"}, err_n, 1);
    check(rd_n == 0 && !busy, {tag, " R9 aborted idle"}, rd_n, 0);
    seek_mode = 0;
  endtask

  task automatic t_prog_timeout();
    dev_ready = 0;
    clear_logs();
    kick(1, 512, 0);
    wait_end();
    check(prog_n == 1 && err_n == 1 && done_n == 0, "R10 ready timeout", err_n, 1);
    dev_ready = 1;
  endtask

  task automatic t_busy_ignore();
    clear_logs();
    kick(1, 512, 0);
    repeat (20) @(negedge clk);
    start = 1; op_write = 0; data_len = 13'd100; spare_len = 8'd4;
    @(negedge clk);
    start = 0;
    wait_end();
    repeat (30) @(negedge clk);
    check(done_n == 1 && tx_n == 528 && rd_n == 0 && !busy, "R12 start while busy", tx_n, 528);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_write(1, 0);
    t_write(4, 1);
    t_read(2048, 64, 0, "full");
    t_read(0, 64, 1, "spare-only");
    t_read(1000, 20, 1, "partial");
    t_read(700, 0, 0, "data-only");
    t_read(0, 0, 0, "empty R8");
    t_seek_fault(1, "seek-err");
    t_seek_fault(2, "seek-timeout");
    t_prog_timeout();
    t_busy_ignore();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule